// File: doc/BRIEF.md
# Idle Power Controller

This block puts a processor core into an idle low-power state and brings it back out. Software issues a power-save request; the controller takes one cycle to complete entry, during which it pulses a watchdog clear, and then gates the CPU clock off. The system clock itself is never touched, so peripherals keep running. While idle, a low-power oscillator keep-alive stays asserted if either the watchdog or the fail-safe clock monitor is enabled.

The core wakes on any interrupt whose pending bit and enable bit are both set, on a watchdog timeout, or on reset. On wake the CPU clock comes back in the same cycle as a one-cycle wake pulse. A resume flag tells the core where to continue: at the handler of the interrupt, or at the instruction after the power-save instruction. An interrupt that shows up while entry is still in progress does not abort entry. The controller remembers it, completes entry, and leaves idle straight away.

The states are RUN, ENTERING, IDLE and WAKING. The transitions are:
- RUN to ENTERING on a request.
- ENTERING to IDLE unconditionally.
- IDLE to WAKING on a wake event, or on a deferred interrupt.
- WAKING to RUN unconditionally.
- Any state to RUN on reset.

Top module: `idle_pwr_ctrl`

## Requirements
- R1: While reset (rst_n low) is held and right after it, cpu_clk_en is 1, and wake, wdt_clr, lprc_keep and resume_isr are 0.
- R2: A cycle sampled with save_req high in RUN leads to ENTERING for exactly one cycle and then IDLE; cpu_clk_en is 0 only in IDLE.
- R3: wdt_clr is 1 exactly during the ENTERING cycle and 0 otherwise.
- R4: lprc_keep is 1 exactly when the controller is in IDLE and wdt_en or fscm_en is 1.
- R5: In IDLE, a wake event is any bit i with irq_pend[i] and irq_en[i] both 1, or wdt_timeout at 1. A wake event moves the controller to WAKING at the next edge. A pending bit with a clear enable has no effect.
- R6: wake is 1 for the single WAKING cycle, cpu_clk_en is 1 in that cycle, and the next state is RUN.
- R7: On leaving IDLE, resume_isr becomes 1 if an enabled interrupt caused the wake, even if a timeout coincides, and 0 for a timeout-only wake. It holds until the next wake, and reset clears it.
- R8: An enabled interrupt sampled during ENTERING is remembered. The controller then spends one cycle in IDLE and wakes with resume_isr 1, even if the interrupt has gone away.
- R9: A wdt_timeout sampled during ENTERING is discarded, because the watchdog clear supersedes it. It does not wake the controller.
- R10: save_req has no effect outside RUN.
- R11: Asserting rst_n low returns the controller to RUN from any state without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, always running |
| rst_n | input | 1 | Asynchronous active-low device reset |
| save_req | input | 1 | Power-save request from the core |
| irq_pend | input | N_IRQ | Interrupt pending flags |
| irq_en | input | N_IRQ | Interrupt enable flags |
| wdt_timeout | input | 1 | Watchdog timeout event |
| wdt_en | input | 1 | Watchdog enabled |
| fscm_en | input | 1 | Fail-safe clock monitor enabled |
| cpu_clk_en | output | 1 | CPU clock enable (0 gates the core clock) |
| wdt_clr | output | 1 | Watchdog clear pulse on entry |
| lprc_keep | output | 1 | Keep the low-power oscillator running |
| wake | output | 1 | One-cycle wake indication |
| resume_isr | output | 1 | 1: resume at interrupt handler, 0: at next instruction |

## Verification
Every output is decoded straight from the state register, so a wrong internal state shows at the ports in the very next sample.

- A stuck or skipped ENTERING shows up as a missing or doubled wdt_clr pulse.
- A state that leaves IDLE early or late shows up as cpu_clk_en and wake edges landing on the wrong cycle.

Two problems are held internally and only appear later:
- A lost deferred-interrupt flag shows up two edges after the request, as a controller that stays idle.
- A wrong cause bit shows up on resume_isr in the WAKING cycle.

// File: rtl/idle_pwr_pkg.sv
package idle_pwr_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_ENTER = 2'd1,
        ST_IDLE  = 2'd2,
        ST_WAKE  = 2'd3
    } idle_state_t;
endpackage

// File: rtl/idle_wake_detect.sv
module idle_wake_detect #(
    parameter int N_IRQ = 8
) (
    input  logic [N_IRQ-1:0] irq_pend,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             wdt_timeout,
    output logic             irq_hit,
    output logic             wdt_hit
);
    // Per-line qualification of pending interrupts by their enables.
    logic [N_IRQ-1:0] armed;

    for (genvar i = 0; i < N_IRQ; i++) begin : g_line
        assign armed[i] = irq_pend[i] & irq_en[i];
    end

    assign irq_hit = |armed;
    assign wdt_hit = wdt_timeout;
endmodule

// File: rtl/idle_lprc_keep.sv
import idle_pwr_pkg::*;

module idle_lprc_keep (
    input  idle_state_t state,
    input  logic        wdt_en,
    input  logic        fscm_en,
    output logic        lprc_keep
);
    // The low-power oscillator only matters while the core clock is gated.
    always_comb begin
        lprc_keep = (state == ST_IDLE) && (wdt_en || fscm_en);
    end
endmodule

// File: rtl/idle_fsm.sv
import idle_pwr_pkg::*;

module idle_fsm (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        save_req,
    input  logic        irq_hit,
    input  logic        wdt_hit,
    output idle_state_t state,
    output logic        cpu_clk_en,
    output logic        wdt_clr,
    output logic        wake,
    output logic        resume_isr
);
    idle_state_t state_nx;
    logic        defer_q;
    logic        defer_nx;
    logic        resume_nx;

    // Next-state and side-register decode.
    always_comb begin
        state_nx  = state;
        defer_nx  = defer_q;
        resume_nx = resume_isr;
        unique case (state)
            ST_RUN: begin
                defer_nx = 1'b0;
                if (save_req) state_nx = ST_ENTER;
            end
            ST_ENTER: begin
                // Interrupt arriving during entry is held, not an abort.
                defer_nx = irq_hit;
                state_nx = ST_IDLE;
            end
            ST_IDLE: begin
                if (irq_hit || defer_q) begin
                    state_nx  = ST_WAKE;
                    resume_nx = 1'b1;
                    defer_nx  = 1'b0;
                end else if (wdt_hit) begin
                    state_nx  = ST_WAKE;
                    resume_nx = 1'b0;
                end
            end
            ST_WAKE: begin
                state_nx = ST_RUN;
            end
            default: state_nx = ST_RUN;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_RUN;
            defer_q    <= 1'b0;
            resume_isr <= 1'b0;
        end else begin
            state      <= state_nx;
            defer_q    <= defer_nx;
            resume_isr <= resume_nx;
        end
    end

    // Moore outputs.
    always_comb begin
        cpu_clk_en = 1'b1;
        wdt_clr    = 1'b0;
        wake       = 1'b0;
        unique case (state)
            ST_RUN:   ;
            ST_ENTER: wdt_clr = 1'b1;
            ST_IDLE:  cpu_clk_en = 1'b0;
            ST_WAKE:  wake = 1'b1;
            default:  ;
        endcase
    end

    // R2: entry lasts exactly one cycle.
    p_enter_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ENTER) |=> (state == ST_IDLE));

    // R3: the watchdog clear is followed by the gated clock.
    p_clr_then_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clr |=> !cpu_clk_en);

    // R6: wake lasts one cycle and always comes out of a gated cycle.
    p_wake_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !wake);
    p_wake_after_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake) |-> $past(!cpu_clk_en));

    // R8: a deferred interrupt produces the wake two edges later.
    p_deferred_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ENTER && irq_hit) |-> ##2 wake);

    // R7: a timeout-only wake reports the next-instruction resume point.
    p_resume_wdt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !irq_hit && !defer_q && wdt_hit) |=> !resume_isr);

    // R10: a request while idle and quiet changes nothing.
    p_req_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !irq_hit && !defer_q && !wdt_hit) |=> (state == ST_IDLE));
endmodule

// File: rtl/idle_pwr_ctrl.sv
import idle_pwr_pkg::*;

module idle_pwr_ctrl #(
    parameter int N_IRQ = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             save_req,
    input  logic [N_IRQ-1:0] irq_pend,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             wdt_timeout,
    input  logic             wdt_en,
    input  logic             fscm_en,
    output logic             cpu_clk_en,
    output logic             wdt_clr,
    output logic             lprc_keep,
    output logic             wake,
    output logic             resume_isr
);
    idle_state_t state;
    logic        irq_hit;
    logic        wdt_hit;

    idle_wake_detect #(.N_IRQ(N_IRQ)) u_detect (
        .irq_pend    (irq_pend),
        .irq_en      (irq_en),
        .wdt_timeout (wdt_timeout),
        .irq_hit     (irq_hit),
        .wdt_hit     (wdt_hit)
    );

    idle_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .save_req   (save_req),
        .irq_hit    (irq_hit),
        .wdt_hit    (wdt_hit),
        .state      (state),
        .cpu_clk_en (cpu_clk_en),
        .wdt_clr    (wdt_clr),
        .wake       (wake),
        .resume_isr (resume_isr)
    );

    idle_lprc_keep u_keep (
        .state     (state),
        .wdt_en    (wdt_en),
        .fscm_en   (fscm_en),
        .lprc_keep (lprc_keep)
    );

    // R4: the keep-alive is never raised while the core clock runs.
    p_keep_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lprc_keep |-> !cpu_clk_en);
endmodule

// File: tb/idle_pwr_ctrl_test.sv
module idle_pwr_ctrl_test;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         save_req;
    logic [N-1:0] irq_pend;
    logic [N-1:0] irq_en;
    logic         wdt_timeout;
    logic         wdt_en;
    logic         fscm_en;
    logic         cpu_clk_en;
    logic         wdt_clr;
    logic         lprc_keep;
    logic         wake;
    logic         resume_isr;

    always #5 clk = ~clk;

    idle_pwr_ctrl #(.N_IRQ(N)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .save_req    (save_req),
        .irq_pend    (irq_pend),
        .irq_en      (irq_en),
        .wdt_timeout (wdt_timeout),
        .wdt_en      (wdt_en),
        .fscm_en     (fscm_en),
        .cpu_clk_en  (cpu_clk_en),
        .wdt_clr     (wdt_clr),
        .lprc_keep   (lprc_keep),
        .wake        (wake),
        .resume_isr  (resume_isr)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Bench model: 0 run, 1 entering, 2 idle, 3 waking.
    int m_st  = 0;
    bit m_def = 1'b0;
    bit m_res = 1'b0;

    function automatic bit any_irq(logic [N-1:0] p, logic [N-1:0] e);
        return |(p & e);
    endfunction

    task automatic check(string req, string sig, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, sig, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_st  = 0;
        m_def = 1'b0;
        m_res = 1'b0;
    endtask

    task automatic model_step();
        bit ih;
        ih = any_irq(irq_pend, irq_en);
        case (m_st)
            0: begin
                m_def = 1'b0;
                if (save_req) m_st = 1;
            end
            1: begin
                m_def = ih;
                m_st  = 2;
            end
            2: begin
                if (ih || m_def) begin
                    m_st = 3; m_res = 1'b1; m_def = 1'b0;
                end else if (wdt_timeout) begin
                    m_st = 3; m_res = 1'b0;
                end
            end
            default: m_st = 0;
        endcase
    endtask

    task automatic compare_all();
        check("R2", "cpu_clk_en", cpu_clk_en, m_st != 2);
        check("R3", "wdt_clr", wdt_clr, m_st == 1);
        check("R4", "lprc_keep", lprc_keep, (m_st == 2) && (wdt_en || fscm_en));
        check("R6", "wake", wake, m_st == 3);
        check("R7", "resume_isr", resume_isr, m_res);
    endtask

    task automatic cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic enter_idle();
        save_req = 1'b1;
        cycle();
        save_req = 1'b0;
        cycle();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd915));
        rst_n = 1'b0; save_req = 1'b0; irq_pend = '0; irq_en = '0;
        wdt_timeout = 1'b0; wdt_en = 1'b1; fscm_en = 1'b0;
        repeat (2) @(negedge clk);
        model_reset();
        // R1: values while reset is held.
        check("R1", "cpu_clk_en", cpu_clk_en, 1'b1);
        check("R1", "wake", wake, 1'b0);
        check("R1", "wdt_clr", wdt_clr, 1'b0);
        check("R1", "lprc_keep", lprc_keep, 1'b0);
        check("R1", "resume_isr", resume_isr, 1'b0);
        rst_n = 1'b1;
        cycle();

        // R2 R5 R6 R7: basic interrupt wake.
        irq_en = 8'hFF;
        enter_idle();
        check("R2", "cpu_clk_en in idle", cpu_clk_en, 1'b0);
        irq_pend = 8'h08;
        cycle();
        check("R6", "wake on irq", wake, 1'b1);
        check("R7", "resume_isr irq", resume_isr, 1'b1);
        irq_pend = '0;
        cycle();

        // R8: interrupt pulse only during entry.
        save_req = 1'b1;
        cycle();
        save_req = 1'b0;
        irq_pend = 8'h01;
        cycle();
        irq_pend = '0;
        cycle();
        check("R8", "deferred wake", wake, 1'b1);
        check("R8", "deferred resume", resume_isr, 1'b1);
        cycle();

        // R9: timeout during entry discarded.
        save_req = 1'b1;
        cycle();
        save_req = 1'b0;
        wdt_timeout = 1'b1;
        cycle();
        wdt_timeout = 1'b0;
        cycle();
        check("R9", "no wake after entry timeout", wake, 1'b0);
        check("R9", "still gated", cpu_clk_en, 1'b0);
        // R5: masked pending lines ignored.
        irq_pend = 8'hFF; irq_en = 8'h00;
        cycle();
        check("R5", "masked irq no wake", wake, 1'b0);
        // R10: request while idle ignored.
        save_req = 1'b1;
        cycle();
        save_req = 1'b0;
        check("R10", "req in idle ignored", cpu_clk_en, 1'b0);
        // R4: keep-alive follows enables while idle.
        wdt_en = 1'b0; fscm_en = 1'b0;
        #1 check("R4", "keep off", lprc_keep, 1'b0);
        fscm_en = 1'b1;
        #1 check("R4", "keep via fscm", lprc_keep, 1'b1);
        // R7: timeout-only wake.
        irq_pend = '0; wdt_timeout = 1'b1;
        cycle();
        check("R7", "resume_isr wdt", resume_isr, 1'b0);
        check("R5", "wake on timeout", wake, 1'b1);
        wdt_timeout = 1'b0;
        cycle();

        // R7: interrupt wins over a coincident timeout.
        irq_en = 8'h10;
        enter_idle();
        irq_pend = 8'h10; wdt_timeout = 1'b1;
        cycle();
        check("R7", "irq priority", resume_isr, 1'b1);
        irq_pend = '0; wdt_timeout = 1'b0;
        cycle();

        // R11: asynchronous reset from IDLE.
        enter_idle();
        rst_n = 1'b0;
        #2;
        check("R11", "clock back on reset", cpu_clk_en, 1'b1);
        check("R11", "resume cleared", resume_isr, 1'b0);
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
        cycle();

        // Random mix.
        for (int k = 0; k < 4000; k++) begin
            save_req    = ($urandom_range(0, 7) == 0);
            irq_pend    = ($urandom_range(0, 9) == 0) ? N'($urandom) : '0;
            irq_en      = N'($urandom);
            wdt_timeout = ($urandom_range(0, 19) == 0);
            if ($urandom_range(0, 31) == 0) begin
                wdt_en  = 1'($urandom);
                fscm_en = 1'($urandom);
            end
            if ($urandom_range(0, 499) == 0) begin
                rst_n = 1'b0;
                #1;
                model_reset();
                compare_all();
                @(negedge clk);
                rst_n = 1'b1;
            end else begin
                cycle();
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule